// File: doc/BRIEF.md
# Serial Port Status Flags and Interrupt Request

This block keeps the eight status flags of a serial port and decides when each one is cleared. The transmitter and receiver send single-cycle event pulses that raise flags. Bus strobes for status reads, data-register reads and writes, and status writes lower them, each according to its own access rule. The flags are gated by per-source enable inputs and combined into one interrupt request.

The clearing rules depend on order. A status read arms a one-deep sequence tracker. The next data-register access uses up that arming. That access is a read for the error and idle flags, and a write for the transfer-complete flag. A flag raised by an event in the same cycle as a clearing access stays set, so an event that coincides with a clearing access is not lost.

Top module: `sio_flag_unit`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `status` reads 0xC0 (transmit-empty and transfer-complete set) and the tracker is disarmed.
- R2: A pulse on `evt_pulse[k]` sets `status[k]` on the next clock. The bit positions are: 7 transmit data empty, 6 transfer complete, 5 receive data ready, 4 idle line, 3 overrun, 2 noise, 1 framing, 0 parity.
- R3: Status bits 4 to 0 clear only on a data read that follows an earlier status read with no data access in between. A data read that is not armed leaves them unchanged.
- R4: Bit 5 clears on every data read, whether or not the tracker is armed.
- R5: Bit 6 clears on a data write that follows an earlier status read with no data access in between. A data write that is not armed leaves bit 6 unchanged.
- R6: Bit 7 clears on any data write and on nothing else. Status reads and status writes leave it unchanged.
- R7: A status write clears bit 6 if `stat_wdata[6]` is 0 and bit 5 if `stat_wdata[5]` is 0. A 1 in either position, and every other bit of the written value, leaves the flags unchanged.
- R8: A status read arms the tracker. The first later data access of either kind disarms it. A data access in the same cycle as a status read does not count that read, and the tracker is left armed.
- R9: When an event pulse and a clearing condition hit the same flag in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some flag is set and its enable is high. `ien_par` gates bit 0, `ien_err` gates bits 1 to 3 together, and `ien_idle`, `ien_rxne`, `ien_tc` and `ien_txe` gate bits 4, 5, 6 and 7 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 8 | Flag-raising event pulses, one per status bit position |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Value written with `stat_wr` |
| ien_par | input | 1 | Parity interrupt enable |
| ien_txe | input | 1 | Transmit-empty interrupt enable |
| ien_tc | input | 1 | Transfer-complete interrupt enable |
| ien_rxne | input | 1 | Receive-ready interrupt enable |
| ien_idle | input | 1 | Idle-line interrupt enable |
| ien_err | input | 1 | Shared enable for framing, noise and overrun |
| status | output | 8 | Current status flags |
| irq | output | 1 | Interrupt request |

## Verification
The critical collision is an event pulse that arrives in the same cycle as the bus access that would clear the same flag. The bench provokes it in two ways. First, it arms the tracker and then drives a data read together with noise and receive-ready pulses. Second, it drives a data write together with a transmit-empty pulse. Both flags must read set afterwards. A related collision is a status read and a data read in the same cycle: that read must not clear the error flags, and it must leave the tracker armed for the next read.

// File: rtl/sio_flag_pkg.sv
package sio_flag_pkg;

    localparam int FLAG_W = 8;

    localparam int B_PE   = 0;
    localparam int B_FE   = 1;
    localparam int B_NE   = 2;
    localparam int B_ORE  = 3;
    localparam int B_IDLE = 4;
    localparam int B_RXNE = 5;
    localparam int B_TC   = 6;
    localparam int B_TXE  = 7;

    localparam logic [FLAG_W-1:0] STAT_RST    = 8'hC0;
    // flags cleared by an armed data read
    localparam logic [FLAG_W-1:0] SEQ_RD_MASK = 8'h1F;
    // flags a status write may clear with a zero
    localparam logic [FLAG_W-1:0] SW_CLR_MASK = (FLAG_W'(1) << B_TC) | (FLAG_W'(1) << B_RXNE);

    typedef struct packed {
        logic txe;
        logic tc;
        logic rxne;
        logic idle;
        logic ore;
        logic ne;
        logic fe;
        logic pe;
    } sio_stat_t;

    typedef struct packed {
        logic err;
        logic idle;
        logic rxne;
        logic tc;
        logic txe;
        logic par;
    } sio_ien_t;

    typedef struct packed {
        logic stat_rd;
        logic data_rd;
        logic data_wr;
        logic stat_wr;
    } sio_bus_t;

    function automatic logic [FLAG_W-1:0] clear_mask(
        input sio_bus_t          bus,
        input logic              armed,
        input logic [FLAG_W-1:0] wdata
    );
        logic [FLAG_W-1:0] c;
        c = '0;
        if (bus.data_rd && armed) c = c | SEQ_RD_MASK;
        if (bus.data_rd)          c[B_RXNE] = 1'b1;
        if (bus.data_wr && armed) c[B_TC]   = 1'b1;
        if (bus.data_wr)          c[B_TXE]  = 1'b1;
        if (bus.stat_wr)          c = c | (~wdata & SW_CLR_MASK);
        return c;
    endfunction

endpackage

// File: rtl/sio_arm_track.sv
module sio_arm_track (
    input  logic clk,
    input  logic rst,
    input  logic stat_rd,
    input  logic data_acc,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst)           armed <= 1'b0;
        else if (stat_rd)  armed <= 1'b1;
        else if (data_acc) armed <= 1'b0;
    end

    // R8: status read arms the tracker
    p_arm_set_r8: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> armed);
    // R8: a data access without a fresh status read disarms it
    p_arm_use_r8: assert property (@(posedge clk) disable iff (rst)
        (data_acc && !stat_rd) |=> !armed);
endmodule

// File: rtl/sio_flag_cell.sv
module sio_flag_cell #(
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= RST_VAL;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);
    p_clear_takes_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/sio_irq_merge.sv
module sio_irq_merge
    import sio_flag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sio_stat_t stat,
    input  sio_ien_t  en,
    output logic      irq
);
    logic err_any;
    assign err_any = stat.fe | stat.ne | stat.ore;

    always_comb begin
        irq = (stat.pe   & en.par)
            | (stat.txe  & en.txe)
            | (stat.tc   & en.tc)
            | (stat.rxne & en.rxne)
            | (stat.idle & en.idle)
            | (err_any   & en.err);
    end

    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (en == '0) |-> !irq);
    p_err_group_r10: assert property (@(posedge clk) disable iff (rst)
        (en.err && (stat.ne || stat.fe || stat.ore)) |-> irq);
endmodule

// File: rtl/sio_flag_unit.sv
module sio_flag_unit
    import sio_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [FLAG_W-1:0] evt_pulse,
    input  logic              stat_rd,
    input  logic              data_rd,
    input  logic              data_wr,
    input  logic              stat_wr,
    input  logic [FLAG_W-1:0] stat_wdata,
    input  logic              ien_par,
    input  logic              ien_txe,
    input  logic              ien_tc,
    input  logic              ien_rxne,
    input  logic              ien_idle,
    input  logic              ien_err,
    output logic [FLAG_W-1:0] status,
    output logic              irq
);
    sio_bus_t          bus;
    sio_ien_t          ien;
    logic              armed;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] stat_q;

    assign bus = '{stat_rd: stat_rd, data_rd: data_rd, data_wr: data_wr, stat_wr: stat_wr};
    assign ien = '{err: ien_err, idle: ien_idle, rxne: ien_rxne,
                   tc: ien_tc, txe: ien_txe, par: ien_par};

    sio_arm_track u_arm (
        .clk      (clk),
        .rst      (rst),
        .stat_rd  (stat_rd),
        .data_acc (data_rd | data_wr),
        .armed    (armed)
    );

    assign clr_vec = clear_mask(bus, armed, stat_wdata);

    for (genvar g = 0; g < FLAG_W; g++) begin : g_flag
        sio_flag_cell #(.RST_VAL(STAT_RST[g])) u_cell (
            .clk   (clk),
            .rst   (rst),
            .set_i (evt_pulse[g]),
            .clr_i (clr_vec[g]),
            .q_o   (stat_q[g])
        );
    end

    sio_irq_merge u_irq (
        .clk  (clk),
        .rst  (rst),
        .stat (sio_stat_t'(stat_q)),
        .en   (ien),
        .irq  (irq)
    );

    assign status = stat_q;

    // R6: transmit-empty only falls after a data write
    p_txe_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q[B_TXE]) |-> $past(data_wr));
    // R3: error/idle flags only fall after a data read
    p_err_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (|($past(stat_q) & ~stat_q & SEQ_RD_MASK)) |-> $past(data_rd));
    // R5, R7: transfer-complete only falls after a data write or status write
    p_tc_fall_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_q[B_TC]) |-> ($past(data_wr) || $past(stat_wr)));
    // R1: reset value seen the cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (stat_q == STAT_RST));
endmodule

// File: tb/sio_flag_unit_tb.sv
`timescale 1ns/1ps
module sio_flag_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] evt_pulse = '0;
    logic       stat_rd = 0, data_rd = 0, data_wr = 0, stat_wr = 0;
    logic [7:0] stat_wdata = '0;
    logic       ien_par = 0, ien_txe = 0, ien_tc = 0, ien_rxne = 0, ien_idle = 0, ien_err = 0;
    logic [7:0] status;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    sio_flag_unit dut_i (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse),
        .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .ien_par(ien_par), .ien_txe(ien_txe), .ien_tc(ien_tc),
        .ien_rxne(ien_rxne), .ien_idle(ien_idle), .ien_err(ien_err),
        .status(status), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // one clock with the given strobes; returns at the next falling edge
    task automatic step(input logic [7:0] ev, input bit srd, input bit drd,
                        input bit dwr, input bit swr, input logic [7:0] wd);
        evt_pulse = ev; stat_rd = srd; data_rd = drd; data_wr = dwr;
        stat_wr = swr; stat_wdata = wd;
        @(negedge clk);
        evt_pulse = '0; stat_rd = 0; data_rd = 0; data_wr = 0; stat_wr = 0; stat_wdata = '0;
    endtask

    task automatic set_en(input bit p, input bit tx, input bit tc, input bit rx,
                          input bit id, input bit er);
        ien_par = p; ien_txe = tx; ien_tc = tc; ien_rxne = rx; ien_idle = id; ien_err = er;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 status during reset", status, 8'hC0);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk("R1 status after reset", status, 8'hC0);
        chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_set();
        step(8'h15, 0, 0, 0, 0, 8'h00);
        chk("R2 events set bits 4,2,0", status, 8'hD5);
    endtask

    task automatic t_err_clear();
        step(8'h00, 0, 1, 0, 0, 8'h00);
        chk("R3 unarmed data read keeps errors", status, 8'hD5);
        step(8'h00, 1, 0, 0, 0, 8'h00);
        step(8'h00, 0, 1, 0, 0, 8'h00);
        chk("R3 status read then data read clears", status, 8'hC0);
    endtask

    task automatic t_rxne();
        step(8'h20, 0, 0, 0, 0, 8'h00);
        chk("R2 rx event", status, 8'hE0);
        step(8'h00, 0, 1, 0, 0, 8'h00);
        chk("R4 plain data read clears rx flag", status, 8'hC0);
    endtask

    task automatic t_tc();
        step(8'h00, 0, 0, 1, 0, 8'h00);
        chk("R5 unarmed write keeps tc, R6 clears txe", status, 8'h40);
        step(8'h00, 1, 0, 0, 0, 8'h00);
        step(8'h00, 0, 0, 1, 0, 8'h00);
        chk("R5 status read then data write clears tc", status, 8'h00);
    endtask

    task automatic t_txe();
        step(8'h80, 0, 0, 0, 0, 8'h00);
        step(8'h00, 1, 0, 0, 0, 8'h00);
        chk("R6 status read keeps txe", status, 8'h80);
        step(8'h00, 0, 0, 0, 1, 8'h00);
        chk("R6 status write keeps txe", status, 8'h80);
    endtask

    task automatic t_swclear();
        step(8'h60, 0, 0, 0, 0, 8'h00);
        step(8'h00, 0, 0, 0, 1, 8'hFF);
        chk("R7 writing ones leaves flags", status, 8'hE0);
        step(8'h00, 0, 0, 0, 1, 8'hBF);
        chk("R7 zero in bit 6 clears tc", status, 8'hA0);
        step(8'h01, 0, 0, 0, 0, 8'h00);
        step(8'h00, 0, 0, 0, 1, 8'h00);
        chk("R7 zero clears rx only, parity kept", status, 8'h81);
        step(8'h00, 1, 0, 0, 0, 8'h00);
        step(8'h00, 0, 1, 0, 0, 8'h00);
        chk("R3 cleanup", status, 8'h80);
    endtask

    task automatic t_arm();
        step(8'h08, 0, 0, 0, 0, 8'h00);
        step(8'h00, 1, 0, 0, 0, 8'h00);
        step(8'h00, 0, 0, 1, 0, 8'h00);
        chk("R8 data write consumes arming", status, 8'h08);
        step(8'h00, 0, 1, 0, 0, 8'h00);
        chk("R8 later read is unarmed", status, 8'h08);
        step(8'h00, 1, 1, 0, 0, 8'h00);
        chk("R8 same-cycle read does not count", status, 8'h08);
        step(8'h00, 0, 1, 0, 0, 8'h00);
        chk("R8 tracker left armed", status, 8'h00);
    endtask

    task automatic t_priority();
        step(8'h04, 0, 0, 0, 0, 8'h00);
        step(8'h00, 1, 0, 0, 0, 8'h00);
        step(8'h24, 0, 1, 0, 0, 8'h00);
        chk("R9 set beats armed read clear", status, 8'h24);
        step(8'h80, 0, 0, 1, 0, 8'h00);
        chk("R9 set beats write clear", status, 8'hA4);
    endtask

    task automatic t_irq();
        set_en(0, 0, 0, 0, 0, 0);
        chk("R10 no enables", {7'b0, irq}, 8'h00);
        set_en(0, 1, 0, 0, 0, 0);
        chk("R10 txe enable", {7'b0, irq}, 8'h01);
        set_en(0, 0, 0, 0, 0, 1);
        chk("R10 error enable covers noise", {7'b0, irq}, 8'h01);
        set_en(1, 0, 0, 0, 1, 0);
        chk("R10 parity and idle clear", {7'b0, irq}, 8'h00);
        step(8'h01, 0, 0, 0, 0, 8'h00);
        chk("R10 parity raises irq", {7'b0, irq}, 8'h01);
        set_en(1, 1, 1, 1, 1, 1);
        step(8'h00, 1, 0, 0, 0, 8'h00);
        step(8'h00, 0, 1, 0, 0, 8'h00);
        chk("R3 errors and rx cleared", status, 8'h80);
        step(8'h00, 0, 0, 1, 0, 8'h00);
        chk("R10 all enabled, no flags", {7'b0, irq}, 8'h00);
        set_en(0, 0, 1, 0, 0, 0);
        step(8'h40, 0, 0, 0, 0, 8'h00);
        chk("R10 tc enable", {7'b0, irq}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_set();
        t_err_clear();
        t_rxne();
        t_tc();
        t_txe();
        t_swclear();
        t_arm();
        t_priority();
        t_irq();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule